// File: doc/BRIEF.md
# Two-Clock Processor Mailbox with Message-Type Flags

This block connects a master processor and one slave processor that run on unrelated clocks. The master sends single bytes to the slave through a forward buffer. The slave returns a status byte through a back buffer.

The kind of a forward byte is not carried inside the byte. It travels as a 3-bit flag code shown on the slave's side, next to an interrupt line. The master sees two flags of its own:
- a "reply outstanding" flag, set by every master command and cleared by the slave's read;
- a "status waiting" flag, set when the slave posts a status byte.

Each command is a one-cycle pulse in the issuing side's clock domain. A command that has an effect on the far side crosses over through a toggle request, a two-flop synchronizer and a returned acknowledge. While that exchange is in flight the issuing side shows busy. The layout of bits inside the bytes belongs to software.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, s_code is 000, s_irq, m_pending, m_status_full, m_busy and s_busy are 0, and m_rdata and s_rdata are zero.
- R2: The master command codes KEY=0, TASK=1 and DATA=2 load m_wdata into the forward buffer. They set s_code (bit 2 = EF4, bit 1 = EF3, bit 0 = EF2) to 110, 101 and 111 respectively.
- R3: The master command INTRPT=3 loads the forward buffer, sets s_code to 001 and raises s_irq.
- R4: Every accepted master command (codes 0 to 4) sets m_pending.
- R5: The slave command READ=0 places the forward buffer on s_rdata, clears s_code to 000, and clears m_pending once it has crossed to the master side.
- R6: The slave command WRITE STATUS=1 loads s_wdata into the back buffer and sets m_status_full.
- R7: The master command READ STATUS=4 places the back buffer on m_rdata, clears m_status_full and sets s_code bit 2 without touching bits 1 and 0. A following slave READ clears s_code and m_pending.
- R8: s_irq stays high until the slave command CLEAR IRQ=2 or reset. CLEAR IRQ leaves s_code unchanged.
- R9: A command issued while its own side shows busy is ignored. Busy falls only after the far side has applied the command.
- R10: The master codes 5 to 7 and the slave code 3 are ignored and do not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Master clock |
| m_rst_n | input | 1 | Master-side asynchronous reset, active low |
| m_cmd_valid | input | 1 | Master command strobe |
| m_cmd | input | 3 | Master command code |
| m_wdata | input | DW | Byte sent with a master command |
| m_rdata | output | DW | Status byte returned by READ STATUS |
| m_busy | output | 1 | Master command crossing in progress |
| m_pending | output | 1 | Slave has not answered the last master command (EF4) |
| m_status_full | output | 1 | Status byte waiting for the master (EF3) |
| s_clk | input | 1 | Slave clock |
| s_rst_n | input | 1 | Slave-side asynchronous reset, active low |
| s_cmd_valid | input | 1 | Slave command strobe |
| s_cmd | input | 2 | Slave command code |
| s_wdata | input | DW | Status byte for WRITE STATUS |
| s_rdata | output | DW | Forward byte returned by READ |
| s_busy | output | 1 | Slave command crossing in progress |
| s_code | output | 3 | Message-type flags EF4, EF3, EF2 |
| s_irq | output | 1 | Interrupt request to the slave |

## Verification
The hardest case to reach is a second command that arrives while the first is still crossing between the clocks. That window lasts only a few cycles of the two unrelated clocks. The stimulus reaches it by holding the command strobe for two consecutive cycles on the same side. The second pulse must then be ignored, and the bench shows this by reading back the forward byte or the status flag. Random sequences across both sides, using clocks of 5 ns and 7 ns, then cover the interplay of READ STATUS, dummy reads and the interrupt.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int DW = 8
) (
  input  logic          m_clk,
  input  logic          m_rst_n,
  input  logic          m_cmd_valid,
  input  logic [2:0]    m_cmd,
  input  logic [DW-1:0] m_wdata,
  output logic [DW-1:0] m_rdata,
  output logic          m_busy,
  output logic          m_pending,
  output logic          m_status_full,
  input  logic          s_clk,
  input  logic          s_rst_n,
  input  logic          s_cmd_valid,
  input  logic [1:0]    s_cmd,
  input  logic [DW-1:0] s_wdata,
  output logic [DW-1:0] s_rdata,
  output logic          s_busy,
  output logic [2:0]    s_code,
  output logic          s_irq
);
  localparam logic [2:0] M_KEY = 3'd0, M_TASK = 3'd1, M_DATA = 3'd2, M_INT = 3'd3, M_RDST = 3'd4;
  localparam logic [1:0] S_RD = 2'd0, S_WR = 2'd1, S_CLR = 2'd2;

  logic          m_req_t, s_req_t, s_kind;
  logic [2:0]    m_kind;
  logic [DW-1:0] m_hold, s_hold, m_status_buf, s_buf;
  logic [1:0]    m_ack_sy, s_ack_sy;
  logic [2:0]    m_ssy, s_msy;
  logic          m_acc, m_sev, s_acc, s_mev;

  assign m_busy = m_req_t ^ m_ack_sy[1];
  assign m_acc  = m_cmd_valid & ~m_busy & (m_cmd <= M_RDST);
  assign m_sev  = m_ssy[1] ^ m_ssy[2];
  assign s_busy = s_req_t ^ s_ack_sy[1];
  assign s_acc  = s_cmd_valid & ~s_busy & (s_cmd != 2'd3);
  assign s_mev  = s_msy[1] ^ s_msy[2];

  always_ff @(posedge m_clk or negedge m_rst_n) begin
    if (!m_rst_n) begin
      m_req_t <= 1'b0;
      m_kind <= '0;
      m_hold <= '0;
      m_ack_sy <= '0;
      m_ssy <= '0;
      m_pending <= 1'b0;
      m_status_full <= 1'b0;
      m_status_buf <= '0;
      m_rdata <= '0;
    end else begin
      m_ack_sy <= {m_ack_sy[0], s_msy[2]};
      m_ssy <= {m_ssy[1:0], s_req_t};
      if (m_sev) begin
        if (!s_kind) m_pending <= 1'b0;
        else begin
          m_status_buf <= s_hold;
          m_status_full <= 1'b1;
        end
      end
      if (m_acc) begin
        m_req_t <= ~m_req_t;
        m_kind <= m_cmd;
        m_hold <= m_wdata;
        m_pending <= 1'b1;
        if (m_cmd == M_RDST) begin
          m_rdata <= m_status_buf;
          if (!(m_sev && s_kind)) m_status_full <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      s_req_t <= 1'b0;
      s_kind <= 1'b0;
      s_hold <= '0;
      s_ack_sy <= '0;
      s_msy <= '0;
      s_code <= '0;
      s_irq <= 1'b0;
      s_buf <= '0;
      s_rdata <= '0;
    end else begin
      s_msy <= {s_msy[1:0], m_req_t};
      s_ack_sy <= {s_ack_sy[0], m_ssy[2]};
      if (s_acc) begin
        case (s_cmd)
          S_RD: begin
            s_rdata <= s_buf;
            s_code <= 3'b000;
            s_kind <= 1'b0;
            s_req_t <= ~s_req_t;
          end
          S_WR: begin
            s_hold <= s_wdata;
            s_kind <= 1'b1;
            s_req_t <= ~s_req_t;
          end
          S_CLR: s_irq <= 1'b0;
          default: ;
        endcase
      end
      if (s_mev) begin
        if (m_kind != M_RDST) s_buf <= m_hold;
        case (m_kind)
          M_KEY:  s_code <= 3'b110;
          M_TASK: s_code <= 3'b101;
          M_DATA: s_code <= 3'b111;
          M_INT: begin
            s_code <= 3'b001;
            s_irq <= 1'b1;
          end
          default: s_code[2] <= 1'b1;
        endcase
      end
    end
  end

  AST_PEND_SET: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    m_acc |=> m_pending); // R4
  AST_RDST_CLEARS: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    (m_acc && m_cmd == M_RDST && !m_sev) |=> !m_status_full); // R7
  AST_STATUS_SET: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    (m_sev && s_kind) |=> m_status_full); // R6
  AST_HOLD_STABLE: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    m_busy |=> $stable(m_hold) && $stable(m_kind)); // R9
  AST_READ_CLEARS: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (s_acc && s_cmd == S_RD && !s_mev) |=> s_code == 3'b000); // R5
  AST_INT_CODE: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (s_mev && m_kind == M_INT) |=> s_irq && s_code == 3'b001); // R3
  AST_IRQ_HOLD: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (s_irq && !(s_acc && s_cmd == S_CLR)) |=> s_irq); // R8
endmodule

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;
  logic m_clk = 0, s_clk = 0, m_rst_n = 0, s_rst_n = 0;
  logic m_cmd_valid = 0, s_cmd_valid = 0;
  logic [2:0] m_cmd = 0;
  logic [1:0] s_cmd = 0;
  logic [7:0] m_wdata = 0, s_wdata = 0;
  logic [7:0] m_rdata, s_rdata;
  logic m_busy, m_pending, m_status_full, s_busy, s_irq;
  logic [2:0] s_code;

  int total = 0, bad = 0, cyc = 0;
  logic [2:0] e_code = 0;
  logic e_irq = 0, e_pend = 0, e_full = 0;
  logic [7:0] e_buf = 0, e_stat = 0, e_mrd = 0, e_srd = 0;

  always #2.5 m_clk = ~m_clk;
  always #3.5 s_clk = ~s_clk;

  ipc_mailbox #(.DW(8)) u0 (
    .m_clk(m_clk), .m_rst_n(m_rst_n), .m_cmd_valid(m_cmd_valid), .m_cmd(m_cmd),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_busy(m_busy), .m_pending(m_pending),
    .m_status_full(m_status_full), .s_clk(s_clk), .s_rst_n(s_rst_n),
    .s_cmd_valid(s_cmd_valid), .s_cmd(s_cmd), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .s_busy(s_busy), .s_code(s_code), .s_irq(s_irq));

  always @(posedge m_clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [2:0] code_after(int c, logic [2:0] old);
    case (c)
      0: return 3'b110;
      1: return 3'b101;
      2: return 3'b111;
      3: return 3'b001;
      default: return old | 3'b100;
    endcase
  endfunction

  task automatic wait_idle();
    int n = 0;
    repeat (2) @(negedge m_clk);
    while ((m_busy || s_busy) && n < 1000) begin
      @(negedge m_clk);
      n++;
    end
    if (n >= 1000) chk("R9 busy never cleared", 1, 0);
    @(negedge s_clk);
    @(negedge m_clk);
  endtask

  task automatic m_op(int c, int d);
    @(negedge m_clk);
    m_cmd_valid = 1; m_cmd = 3'(c); m_wdata = 8'(d);
    @(negedge m_clk);
    m_cmd_valid = 0;
    if (c <= 4) begin
      e_pend = 1;
      e_code = code_after(c, e_code);
      if (c < 4) e_buf = 8'(d);
      if (c == 3) e_irq = 1;
      if (c == 4) begin e_mrd = e_stat; e_full = 0; end
    end
    wait_idle();
  endtask

  task automatic s_op(int c, int d);
    @(negedge s_clk);
    s_cmd_valid = 1; s_cmd = 2'(c); s_wdata = 8'(d);
    @(negedge s_clk);
    s_cmd_valid = 0;
    case (c)
      0: begin e_srd = e_buf; e_code = 0; e_pend = 0; end
      1: begin e_stat = 8'(d); e_full = 1; end
      2: e_irq = 0;
      default: ;
    endcase
    wait_idle();
  endtask

  task automatic check_all(string tag);
    chk({tag, " s_code"}, s_code, e_code);
    chk({tag, " s_irq"}, s_irq, e_irq);
    chk({tag, " m_pending"}, m_pending, e_pend);
    chk({tag, " m_status_full"}, m_status_full, e_full);
    chk({tag, " m_rdata"}, m_rdata, e_mrd);
    chk({tag, " s_rdata"}, s_rdata, e_srd);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge m_clk);
    m_rst_n = 1; s_rst_n = 1;
    @(negedge m_clk);
    check_all("R1 reset");
    chk("R1 m_busy", m_busy, 0);
    chk("R1 s_busy", s_busy, 0);

    m_op(0, 8'hA5); check_all("R2 KEY");
    s_op(0, 0);     check_all("R5 READ after KEY");
    m_op(1, 8'h17); check_all("R2 TASK");
    s_op(0, 0);     check_all("R5 READ after TASK");
    m_op(2, 8'h42); check_all("R2 DATA R4");
    s_op(0, 0);     check_all("R5 READ after DATA");
    m_op(3, 8'h99); check_all("R3 INTRPT");
    s_op(0, 0);     check_all("R8 irq survives READ");
    s_op(2, 0);     check_all("R8 CLEAR IRQ");
    s_op(1, 8'h3C); check_all("R6 WRITE STATUS");
    m_op(4, 0);     check_all("R7 READ STATUS");
    s_op(0, 0);     check_all("R7 dummy READ");

    // R10: unused codes ignored
    @(negedge m_clk); m_cmd_valid = 1; m_cmd = 3'd6; m_wdata = 8'hEE;
    @(negedge m_clk); m_cmd_valid = 0;
    chk("R10 m_busy after unused code", m_busy, 0);
    @(negedge s_clk); s_cmd_valid = 1; s_cmd = 2'd3;
    @(negedge s_clk); s_cmd_valid = 0;
    chk("R10 s_busy after unused code", s_busy, 0);
    wait_idle();
    check_all("R10 no effect");

    // R9: master back-to-back, second dropped
    @(negedge m_clk); m_cmd_valid = 1; m_cmd = 3'd0; m_wdata = 8'h11;
    @(negedge m_clk); m_cmd = 3'd1; m_wdata = 8'h22;
    chk("R9 m_busy during second", m_busy, 1);
    @(negedge m_clk); m_cmd_valid = 0;
    e_pend = 1; e_code = 3'b110; e_buf = 8'h11;
    wait_idle();
    check_all("R9 master drop");
    s_op(0, 0); check_all("R9 forward byte kept");

    // R9: slave READ then WRITE while busy
    m_op(2, 8'h5A);
    @(negedge s_clk); s_cmd_valid = 1; s_cmd = 2'd0;
    @(negedge s_clk); s_cmd = 2'd1; s_wdata = 8'h77;
    chk("R9 s_busy during second", s_busy, 1);
    @(negedge s_clk); s_cmd_valid = 0;
    e_srd = e_buf; e_code = 0; e_pend = 0;
    wait_idle();
    check_all("R9 slave drop");

    for (int i = 0; i < 400; i++) begin
      int r, d;
      r = int'($urandom % 9);
      d = int'($urandom % 256);
      if (r <= 4) m_op(r, d);
      else if (r == 5) m_op(5 + int'($urandom % 3), d);
      else s_op(r - 6, d);
      check_all("R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule